// File: doc/BRIEF.md
# Channel-selected phase-modulated DDFS phase path

This block produces the phase word that feeds a sine lookup in a digital phase modulator. It keeps a small built-in table of frequency control words, one for each fine-tune channel, and a phase accumulator that adds the selected word on every clock. A signed modulation phase sample is added to the accumulated carrier phase. The sum is truncated to its top bits, so the downstream amplitude converter sees a constant-envelope carrier at an intermediate frequency, with the modulation phase riding on it.

The table is computed at elaboration from the clock rate, the frequency of the lowest channel and the channel spacing. With the defaults it holds 25 channels, 200 kHz apart, from 5.0 MHz upward at a 26 MHz clock. The word for channel k is the nearest integer to (BASE + k·STEP)·2^L / f_clk. A select strobe with a channel index retunes the carrier on the next clock without clearing the accumulator, so the carrier phase stays continuous across a hop.

Top module: `ddfs_pm_phase`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, phase_o is 0, the stored channel is 0 and the accumulator is 0.
- R2: The accumulator grows by the word of the stored channel on every clock, modulo 2^L. The word for channel k is round((BASE_HZ + k·STEP_HZ)·2^L / CLK_HZ), and this holds for every channel 0..NUM_CH-1.
- R3: The accumulator wraps modulo 2^L. A step that passes 2^L gives old + word − 2^L, with no saturation and no lost step.
- R4: When sel_i is high and chan_i < NUM_CH at a clock edge, chan_i becomes the stored channel. The accumulator update at that same edge still uses the old word, and later updates use the new word. The accumulator is not cleared.
- R5: While sel_i is low, chan_i has no effect on the stored channel.
- R6: When sel_i is high and chan_i ≥ NUM_CH, the stored channel is kept unchanged.
- R7: At each edge phase_o is loaded with bits [L-1 : L-W] of (acc + M). Here acc is the accumulator value before that edge, and M is mod_i (J-bit two's complement) placed in bits [L-1 : L-J] with zeros below. This gives one clock of latency. mod_i never changes the accumulator itself.
- R8: A negative mod_i wraps the sum modulo 2^L. For example, an accumulator of 0 with mod_i = −1 gives phase_o = 2^W − 2^(L−J) when W = L.
- R9: Every stored word is below 2^(L−1), and with the default channel plan it is at most 0.4·2^L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Channel load strobe |
| chan_i | input | CH_W = clog2(NUM_CH) | Requested channel index |
| mod_i | input | MOD_W | Signed modulation phase sample |
| phase_o | output | OUT_W | Truncated modulated phase word |

## Verification
The bench builds the block with ACC_W = 15, OUT_W = 15 and MOD_W = 12, and keeps the default 25-channel plan at 26 MHz. Because the output width equals the accumulator width, the whole accumulator shows on phase_o. This puts each channel's exact increment, the modulo-2^15 wrap and the three-bit alignment of the modulation sample within direct reach at the port. Words of roughly 6300 to 12350 make the accumulator wrap every few clocks, so wraparound and negative-modulation corners occur in a short run.

// File: rtl/ddfs_phase_pkg.sv
`timescale 1ns/1ps
package ddfs_phase_pkg;

  // Nearest-integer control word for a tone of freq_hz at clock clk_hz
  // with an acc_w-bit accumulator.
  function automatic logic [63:0] fcw_calc(input int unsigned acc_w,
                                           input longint unsigned clk_hz,
                                           input longint unsigned freq_hz);
    logic [63:0] num;
    num = (64'(freq_hz) << acc_w) + 64'(clk_hz / 2);
    return num / 64'(clk_hz);
  endfunction

  // Tone frequency of channel k.
  function automatic longint unsigned chan_freq(input longint unsigned base_hz,
                                                input longint unsigned step_hz,
                                                input int unsigned k);
    return base_hz + step_hz * longint'(k);
  endfunction

endpackage

// File: rtl/ddfs_fcw_table.sv
`timescale 1ns/1ps
module ddfs_fcw_table #(
  parameter int          ACC_W   = 32,
  parameter int          NUM_CH  = 25,
  parameter longint      CLK_HZ  = 26_000_000,
  parameter longint      BASE_HZ = 5_000_000,
  parameter longint      STEP_HZ = 200_000,
  localparam int         CH_W    = $clog2(NUM_CH)
) (
  input  logic [CH_W-1:0]  chan,
  output logic [ACC_W-1:0] step
);
  import ddfs_phase_pkg::*;

  logic [ACC_W-1:0] tbl [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ent
    localparam logic [63:0] WORD =
      fcw_calc(ACC_W, CLK_HZ, chan_freq(BASE_HZ, STEP_HZ, k));
    assign tbl[k] = WORD[ACC_W-1:0];
  end

  always_comb begin
    step = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (chan == CH_W'(k)) step = tbl[k];
    end
  end
endmodule

// File: rtl/ddfs_chan_sel.sv
`timescale 1ns/1ps
module ddfs_chan_sel #(
  parameter  int NUM_CH = 25,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic [CH_W-1:0] chan_req,
  output logic            idx_ok,
  output logic [CH_W-1:0] chan_q
);
  assign idx_ok = ({1'b0, chan_req} < (CH_W+1)'(NUM_CH));

  always_ff @(posedge clk) begin
    if (!rst_n)              chan_q <= '0;
    else if (sel && idx_ok)  chan_q <= chan_req;
  end
endmodule

// File: rtl/ddfs_phase_accum.sv
`timescale 1ns/1ps
module ddfs_phase_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q
);
  function automatic logic [ACC_W-1:0] wrap_add(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= wrap_add(acc_q, step);
  end
endmodule

// File: rtl/ddfs_mod_inject.sv
`timescale 1ns/1ps
module ddfs_mod_inject #(
  parameter int ACC_W = 32,
  parameter int MOD_W = 12,
  parameter int OUT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc,
  input  logic [MOD_W-1:0] mod,
  output logic [OUT_W-1:0] phase_q
);
  // Place the signed sample in the top MOD_W bits; two's complement
  // modulo 2^ACC_W makes this the sign-extended, shifted value.
  function automatic logic [ACC_W-1:0] align_mod(input logic [MOD_W-1:0] m);
    logic [ACC_W-1:0] r;
    r = '0;
    r[ACC_W-1 -: MOD_W] = m;
    return r;
  endfunction

  function automatic logic [OUT_W-1:0] trunc_top(input logic [ACC_W-1:0] s);
    return s[ACC_W-1 -: OUT_W];
  endfunction

  logic [ACC_W-1:0] mod_ext;
  logic [ACC_W-1:0] sum_w;

  assign mod_ext = align_mod(mod);
  assign sum_w   = acc + mod_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= trunc_top(sum_w);
  end
endmodule

// File: rtl/ddfs_pm_phase.sv
`timescale 1ns/1ps
module ddfs_pm_phase #(
  parameter  int     ACC_W   = 32,
  parameter  int     MOD_W   = 12,
  parameter  int     OUT_W   = 15,
  parameter  int     NUM_CH  = 25,
  parameter  longint CLK_HZ  = 26_000_000,
  parameter  longint BASE_HZ = 5_000_000,
  parameter  longint STEP_HZ = 200_000,
  localparam int     CH_W    = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [OUT_W-1:0] phase_o
);
  logic             idx_ok;
  logic [CH_W-1:0]  chan_q;
  logic [ACC_W-1:0] step_w;
  logic [ACC_W-1:0] acc_q;

  ddfs_chan_sel #(.NUM_CH(NUM_CH)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel(sel_i), .chan_req(chan_i),
    .idx_ok(idx_ok), .chan_q(chan_q)
  );

  ddfs_fcw_table #(
    .ACC_W(ACC_W), .NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ),
    .BASE_HZ(BASE_HZ), .STEP_HZ(STEP_HZ)
  ) u_tbl (
    .chan(chan_q), .step(step_w)
  );

  ddfs_phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(step_w), .acc_q(acc_q)
  );

  ddfs_mod_inject #(.ACC_W(ACC_W), .MOD_W(MOD_W), .OUT_W(OUT_W)) u_inj (
    .clk(clk), .rst_n(rst_n), .acc(acc_q), .mod(mod_i), .phase_q(phase_o)
  );
endmodule

// File: rtl/ddfs_pm_phase_chk.sv
`timescale 1ns/1ps
module ddfs_pm_phase_chk #(
  parameter  int ACC_W  = 32,
  parameter  int NUM_CH = 25,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_i,
  input logic [CH_W-1:0]  chan_i,
  input logic             idx_ok,
  input logic [CH_W-1:0]  chan_q,
  input logic [ACC_W-1:0] step_w,
  input logic [ACC_W-1:0] acc_q
);
  localparam logic [ACC_W:0] HALF = {2'b01, {(ACC_W-1){1'b0}}};

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_q == '0 && chan_q == '0));

  // R2 / R3: modulo step by the table word of the previous cycle
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ACC_W'(acc_q - $past(acc_q)) == $past(step_w)));

  a_r4_take: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && idx_ok) |=> (chan_q == $past(chan_i)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(chan_q));

  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !idx_ok) |=> $stable(chan_q));

  a_r9_word_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, step_w} < HALF));
endmodule

bind ddfs_pm_phase ddfs_pm_phase_chk #(.ACC_W(ACC_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .chan_i(chan_i),
  .idx_ok(idx_ok), .chan_q(chan_q), .step_w(step_w), .acc_q(acc_q)
);

// File: tb/tb_ddfs_pm_phase.sv
`timescale 1ns/1ps
module tb_ddfs_pm_phase;
  localparam int L = 15;
  localparam int J = 12;
  localparam int W = 15;
  localparam int NCH = 25;
  localparam int MASK = (1 << L) - 1;

  localparam int NV = 8;
  localparam int VCH  [NV] = '{3, 24, 0, 12, 7, 24, 1, 18};
  localparam int VMOD [NV] = '{0, 511, -2048, 2047, -1, 100, -700, 1};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_i = 1'b0;
  logic [4:0]   chan_i = '0;
  logic [J-1:0] mod_i = '0;
  logic [W-1:0] phase_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int m_acc = 0;
  int m_chan = 0;
  int m_exp = 0;

  always #4 clk = ~clk;

  ddfs_pm_phase #(.ACC_W(L), .MOD_W(J), .OUT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .chan_i(chan_i),
    .mod_i(mod_i), .phase_o(phase_o)
  );

  function automatic int ref_fcw(input int k);
    real f;
    f = 5.0e6 + real'(k) * 2.0e5;
    return $rtoi(f * 32768.0 / 26.0e6 + 0.5);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at the next negedge.
  task automatic tick(input bit s, input int ch, input int md, input string tag);
    sel_i  = s;
    chan_i = ch[4:0];
    mod_i  = md[J-1:0];
    @(posedge clk);
    m_exp = (m_acc + md * (1 << (L - J))) & MASK;
    m_acc = (m_acc + ref_fcw(m_chan)) & MASK;
    if (s && ch >= 0 && ch < NCH) m_chan = ch;
    @(negedge clk);
    chk(tag, int'(phase_o), m_exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sel_i = 1'b0;
    mod_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 phase during reset", int'(phase_o), 0);
    rst_n = 1'b1;
    m_acc = 0;
    m_chan = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a;
    int b;
    int wraps;
    wraps = 0;
    @(negedge clk);
    do_reset();

    // R8: negative modulation right after reset wraps below zero
    tick(0, 0, -1, "R8 neg mod at acc 0");
    chk("R8 explicit", int'(phase_o), 32768 - 8);
    tick(0, 0, 0, "R1 first step from zero");
    chk("R1 one word after reset", int'(phase_o), ref_fcw(0));

    // R2 / R9 / R3: every channel's increment at the port
    for (int k = 0; k < NCH; k++) begin
      tick(1, k, 0, "R4 select");
      tick(0, 0, 0, "R2 settle");
      tick(0, 0, 0, "R2 settle");
      a = int'(phase_o);
      tick(0, 0, 0, "R2 step");
      b = int'(phase_o);
      chk($sformatf("R2 word ch%0d", k), (b - a) & MASK, ref_fcw(k));
      chk($sformatf("R9 below half ch%0d", k), int'(((b - a) & MASK) < 16384), 1);
      chk($sformatf("R9 below 0.4 ch%0d", k), int'(((b - a) & MASK) <= 13107), 1);
      if (b < a) begin
        wraps++;
        chk("R3 wrap value", b, a + ref_fcw(k) - 32768);
      end
    end
    chk("R3 wrap observed", int'(wraps > 0), 1);

    // Vector table: select, hold with ignored index, modulate, resume
    for (int i = 0; i < NV; i++) begin
      tick(1, VCH[i], 0, "R4 vec select");
      tick(0, (VCH[i] + 5) % NCH, 0, "R5 sel low ignored");
      a = int'(phase_o);
      tick(0, 2, 0, "R5 sel low ignored");
      b = int'(phase_o);
      chk("R5 word kept", (b - a) & MASK, ref_fcw(VCH[i]));
      tick(0, 0, VMOD[i], "R7 modulated output");
      tick(0, 0, 0, "R7 accumulator untouched");
    end

    // R4: retune keeps phase continuous (old word at the select edge)
    tick(1, 3, 0, "R4 to ch3");
    tick(0, 0, 0, "R4 settle");
    tick(1, 10, 0, "R4 hop");
    a = int'(phase_o);
    tick(0, 0, 0, "R4 after hop");
    b = int'(phase_o);
    chk("R4 old word at select edge", (b - a) & MASK, ref_fcw(3));
    tick(0, 0, 0, "R4 new word");
    chk("R4 new word applied", (int'(phase_o) - b) & MASK, ref_fcw(10));

    // R6: out-of-range indices are dropped
    tick(1, 25, 0, "R6 index 25");
    tick(1, 31, 0, "R6 index 31");
    a = int'(phase_o);
    tick(0, 0, 0, "R6 hold");
    b = int'(phase_o);
    chk("R6 channel kept", (b - a) & MASK, ref_fcw(10));

    // R7: extremes of the modulation sample
    tick(0, 0, 2047, "R7 max mod");
    tick(0, 0, -2048, "R7 min mod");
    tick(0, 0, 0, "R7 resume");

    // R1: reset in mid-run clears the accumulator and channel
    @(negedge clk);
    do_reset();
    tick(0, 0, 0, "R1 after re-reset");
    tick(0, 0, 0, "R1 channel 0 word");
    chk("R1 channel back to 0", int'(phase_o), ref_fcw(0));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule